// File: doc/BRIEF.md
# Interrupt Source Capture Register

This block collects one-cycle event pulses from four peripheral sources and keeps two bits of state for each of them. The sources are key-on wakeup, UART bus collision, A/D conversion done and timer 1. A discrimination bit notes that a source's event has happened. It is set by every event, even when the source is not enabled. A request bit is set by an event only when the source's enable bit is 1. The interrupt line to the CPU is the OR of the request bits.

Software uses a small register bus to program the enable bits and to inspect and clear the other two bit sets. The discrimination and request registers clear on a written 0 and keep their value on a written 1. A single bit can therefore be acknowledged without a read-modify-write.

Top module: `irq_source_capture`

## Requirements
- R1: After reset, the enable, discrimination and request registers all read 0 and `irqOut` is 0.
- R2: Address 0 holds the enable register, which is fully readable and writable. Address 1 reads the discrimination register. Address 2 reads the request register. Address 3 reads 0, and a write to it changes no state.
- R3: An `evtPulse` bit that is high at a clock edge sets the matching discrimination bit at that edge, whatever the enable bit holds.
- R4: An event on a source whose enable bit is 0 leaves that source's request bit unchanged, whether the bit was 0 or 1.
- R5: An event on a source whose enable bit is 1 sets that source's request bit at the same edge. The enable value used is the one held before that edge.
- R6: A write to address 1 clears every discrimination bit written as 0 and leaves every bit written as 1 unchanged.
- R7: A write to address 2 clears every request bit written as 0 and leaves every bit written as 1 unchanged.
- R8: If an event and a clearing write hit the same bit at the same edge, the bit ends up 1.
- R9: `irqOut` is 1 exactly when at least one request bit is 1.
- R10: In all three registers and in `evtPulse`, bit 0 is key-on wakeup, bit 1 is UART bus collision, bit 2 is A/D conversion done and bit 3 is timer 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Read data for `addr` (combinational) |
| evtPulse | input | 4 | One-cycle event pulses, one per source |
| irqOut | output | 1 | OR of the request bits |

## Verification
A wrong enable gate shows up as a request bit, and so as `irqOut`, in the cycle right after the event. A discrimination bit that fails to set shows on the first read of address 1 after that edge. Clear polarity errors and lost event-versus-clear priority show on the read that follows the write. The bench sweeps every enable pattern against every event pattern, and every clear mask against both registers. Any bit that is stuck, swapped or gated wrongly therefore changes a read within one cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int SRC_N  = 4;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EN   = 2'd0,
    SEL_DISC = 2'd1,
    SEL_REQ  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_t;

  typedef struct packed {
    logic             enWr;
    logic             discWr;
    logic             reqWr;
    logic [SRC_N-1:0] wrBits;
    regSel_t          rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_N-1:0]  wrData,
  output ctrlStrobes_t      strobes
);
  regSel_t sel;

  always_comb begin
    sel = regSel_t'(addr);
    strobes        = '0;
    strobes.rdSel  = sel;
    strobes.wrBits = wrData;
    strobes.enWr   = wrEn && (sel == SEL_EN);
    strobes.discWr = wrEn && (sel == SEL_DISC);
    strobes.reqWr  = wrEn && (sel == SEL_REQ);
  end
endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [SRC_N-1:0] evtPulse,
  output logic [SRC_N-1:0] rdData,
  output logic             irqOut
);
  logic [SRC_N-1:0] enReg;
  logic [SRC_N-1:0] discReg;
  logic [SRC_N-1:0] reqReg;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    // discrimination bit: event has priority over a clearing write
    always_ff @(posedge clk) begin
      if (!rstN)                                      discReg[i] <= 1'b0;
      else if (evtPulse[i])                           discReg[i] <= 1'b1;
      else if (strobes.discWr && !strobes.wrBits[i])  discReg[i] <= 1'b0;
    end

    // request bit: gated by enable, event beats clear
    always_ff @(posedge clk) begin
      if (!rstN)                                      reqReg[i] <= 1'b0;
      else if (evtPulse[i] && enReg[i])               reqReg[i] <= 1'b1;
      else if (strobes.reqWr && !strobes.wrBits[i])   reqReg[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)             enReg[i] <= 1'b0;
      else if (strobes.enWr) enReg[i] <= strobes.wrBits[i];
    end

    p_evt_sets_disc_r3: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> discReg[i]);

    p_masked_req_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
      (evtPulse[i] && !enReg[i] && !strobes.reqWr) |=> $stable(reqReg[i]));

    p_enabled_evt_req_r5: assert property (@(posedge clk) disable iff (!rstN)
      (evtPulse[i] && enReg[i]) |=> reqReg[i]);

    p_disc_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.discWr && !strobes.wrBits[i] && !evtPulse[i]) |=> !discReg[i]);

    p_disc_rise_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(discReg[i]) |-> $past(evtPulse[i]));
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_EN:   rdData = enReg;
      SEL_DISC: rdData = discReg;
      SEL_REQ:  rdData = reqReg;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = |reqReg;
endmodule

// File: rtl/irq_source_capture.sv
module irq_source_capture
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_N-1:0]  wrData,
  output logic [SRC_N-1:0]  rdData,
  input  logic [SRC_N-1:0]  evtPulse,
  output logic              irqOut
);
  ctrlStrobes_t strobes;

  isc_ctrl ctrl_i (
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .strobes (strobes)
  );

  isc_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .evtPulse (evtPulse),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );

  p_irq_low_after_reset_r1: assert property (@(posedge clk)
    !rstN |=> !irqOut);
endmodule

// File: tb/irq_source_capture_tb_top.sv
module irq_source_capture_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [3:0] wrData = 4'd0;
  logic [3:0] evtPulse = 4'd0;
  logic [3:0] rdData;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_source_capture dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evtPulse(evtPulse), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus/event cycle, driven at the falling edge
  task automatic step(input logic we, input logic [1:0] a, input logic [3:0] d,
                      input logic [3:0] ev);
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; evtPulse = ev;
    @(negedge clk);
    wrEn = 1'b0; evtPulse = 4'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] v);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic clearAll();
    step(1'b1, 2'd1, 4'h0, 4'h0);
    step(1'b1, 2'd2, 4'h0, 4'h0);
  endtask

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 enable", v, 4'h0);
    rd(2'd1, v); chk("R1 disc", v, 4'h0);
    rd(2'd2, v); chk("R1 req", v, 4'h0);
    chk("R1 irq", {3'b0, irqOut}, 4'h0);
    rstN = 1'b1;

    // R2: enable register read/write, address 3 inert
    for (int e = 0; e < 16; e++) begin
      step(1'b1, 2'd0, 4'(e), 4'h0);
      rd(2'd0, v); chk("R2 enable rw", v, 4'(e));
    end
    step(1'b1, 2'd3, 4'h0, 4'h0);
    rd(2'd3, v); chk("R2 addr3 reads 0", v, 4'h0);
    rd(2'd0, v); chk("R2 addr3 write no effect", v, 4'hF);

    // R3 R4 R5 R9 R10: every enable pattern against every event pattern
    for (int e = 0; e < 16; e++) begin
      for (int ev = 0; ev < 16; ev++) begin
        step(1'b1, 2'd0, 4'(e), 4'h0);
        clearAll();
        step(1'b0, 2'd0, 4'h0, 4'(ev));
        rd(2'd1, v); chk("R3 R10 disc set", v, 4'(ev));
        rd(2'd2, v); chk("R4 R5 R10 req gated", v, 4'(e & ev));
        chk("R9 irq", {3'b0, irqOut}, {3'b0, |(4'(e & ev))});
      end
    end

    // R4: masked event keeps an already set request bit at 1
    step(1'b1, 2'd0, 4'hF, 4'h0);
    clearAll();
    step(1'b0, 2'd0, 4'h0, 4'h4);
    step(1'b1, 2'd0, 4'h0, 4'h0);
    step(1'b0, 2'd0, 4'h0, 4'h4);
    rd(2'd2, v); chk("R4 masked keeps 1", v, 4'h4);

    // R5: enable written in same cycle as event uses old value
    step(1'b1, 2'd0, 4'h0, 4'h0);
    clearAll();
    step(1'b1, 2'd0, 4'hF, 4'h2);
    rd(2'd2, v); chk("R5 old enable used", v, 4'h0);

    // R6 R7: every clear mask on both registers
    for (int m = 0; m < 16; m++) begin
      step(1'b1, 2'd0, 4'hF, 4'h0);
      step(1'b0, 2'd0, 4'h0, 4'hF);
      step(1'b1, 2'd1, 4'(m), 4'h0);
      rd(2'd1, v); chk("R6 disc clear mask", v, 4'(m));
      rd(2'd2, v); chk("R6 req untouched", v, 4'hF);
      step(1'b1, 2'd2, 4'(m), 4'h0);
      rd(2'd2, v); chk("R7 req clear mask", v, 4'(m));
      chk("R9 irq after clear", {3'b0, irqOut}, {3'b0, (m != 0)});
    end

    // R8: event beats clearing write on the same bit
    step(1'b1, 2'd0, 4'hF, 4'h0);
    step(1'b0, 2'd0, 4'h0, 4'hF);
    step(1'b1, 2'd1, 4'h0, 4'h4);
    rd(2'd1, v); chk("R8 disc event wins", v, 4'h4);
    step(1'b1, 2'd2, 4'h0, 4'h9);
    rd(2'd2, v); chk("R8 req event wins", v, 4'h9);

    // R1 again: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(2'd0, v); chk("R1 enable after reset", v, 4'h0);
    rd(2'd2, v); chk("R1 req after reset", v, 4'h0);
    chk("R1 irq after reset", {3'b0, irqOut}, 4'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule